// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Lock Indication

This block compares a reference clock-like input with a feedback input, both sampled by a much faster system clock. Each rising edge on the reference sets an up request and each rising edge on the feedback sets a down request. The requests go to a current-steering charge pump outside the block. Once both requests are active, they stay on together for a fixed number of system clocks and then clear. Because of this forced overlap, even a zero phase error yields a short, well-defined pulse on each output, so the loop has no dead zone.

The block has four more outputs. A pulse output is active whenever either request is. A level-sensitive XOR comparator output is meant for inputs with 50% duty cycle. A shared pin carries either the XOR output or the pulse output, chosen by a mode input. A lock flag counts consecutive narrow comparisons. A high inhibit input stops and clears the whole detector.

Top module: `pfd_lock`

## Requirements
- R1: Only rising edges count. `ref_in` sets up and `fb_in` sets down; falling edges and duty cycle have no effect. A rise first sampled at clock edge k shows on `up`/`dn` after clock edge k+2.
- R2: With both inputs rising once, d clocks apart, the leading side's request is high for d+OVERLAP clocks and the lagging side's request for OVERLAP clocks.
- R3: Every comparison, including zero phase error, holds `up` and `dn` high together for exactly OVERLAP clocks, after which both clear in the same cycle.
- R4: `drv_en` is high exactly when `up` or `dn` is high (low means high-impedance). `drv_src` follows `up` and `drv_snk` follows `dn`, so the overlap reports both.
- R5: `pulse_out` is high whenever `up` or `dn` is high, and low after reset.
- R6: `xor_out` is the XOR of the two inputs after two synchroniser stages.
- R7: `shared_out` carries `xor_out` when `bias_mode` is 0 and `pulse_out` when `bias_mode` is 1.
- R8: While `inhibit` is high, every output except `shared_out`'s source selection is low, and detector and lock state are cleared. A rising edge seen only during inhibit is dropped.
- R9: A rising edge that arrives during the overlap, including on its final clock, is held. It sets its request again on the clock that clears the overlap, so it is never lost.
- R10: A comparison's width counts the clocks from the first request to the end of the overlap. `locked` rises after LOCK_COUNT consecutive comparisons of width at most OVERLAP+TOL. It falls on the first wider comparison.
- R11: When the reference runs at a higher frequency than the feedback, `up` is high for more cycles than `dn`. The reverse holds when the feedback is faster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than both inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| inhibit | input | 1 | High disables and clears the block |
| bias_mode | input | 1 | Shared pin select: 0 XOR, 1 pulse |
| ref_in | input | 1 | Reference input, asynchronous |
| fb_in | input | 1 | Feedback input, asynchronous |
| up | output | 1 | Charge-up request |
| dn | output | 1 | Charge-down request |
| drv_en | output | 1 | Pump drive enabled (low: high-impedance) |
| drv_src | output | 1 | Pump sourcing current |
| drv_snk | output | 1 | Pump sinking current |
| pulse_out | output | 1 | Comparator pulse, up or down active |
| xor_out | output | 1 | XOR phase comparator output |
| shared_out | output | 1 | Mode-selected shared pin |
| locked | output | 1 | Lock flag |

## Verification
The clearing of the overlap and the arrival of a fresh input edge can fall in the same clock. The bench provokes this by re-raising the reference two, three and four clocks after a zero-error comparison starts. The three offsets put the new edge inside the overlap, exactly on its clearing clock, and just after it. The bench then counts the total clocks of `up` and `dn` across the window. A held edge gives an unbroken `up` of 11 clocks, a late edge gives 10, and `dn` gives 6 in every case. A behavioural model compares all outputs on every clock as well.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int OVERLAP    = 3,
  parameter int TOL        = 2,
  parameter int LOCK_COUNT = 4,
  parameter int CNT_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  input  logic bias_mode,
  input  logic ref_in,
  input  logic fb_in,
  output logic up,
  output logic dn,
  output logic drv_en,
  output logic drv_src,
  output logic drv_snk,
  output logic pulse_out,
  output logic xor_out,
  output logic shared_out,
  output logic locked
);
  localparam int OVW   = (OVERLAP > 1) ? $clog2(OVERLAP) : 1;
  localparam int LKW   = $clog2(LOCK_COUNT + 1);
  localparam int LIMIT = OVERLAP + TOL;
  localparam logic [OVW-1:0] OV_LAST = OVW'(OVERLAP - 1);
  localparam logic [LKW-1:0] LK_FULL = LKW'(LOCK_COUNT);

  logic [2:0] ref_sh, fb_sh;
  logic ref_rise, fb_rise;
  logic up_q, dn_q, pend_r, pend_f, both, cmp_end, narrow, lock_q;
  logic [OVW-1:0] ovc;
  logic [CNT_W-1:0] pw;
  logic [CNT_W:0] width_now;
  logic [LKW-1:0] good, good_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_in};
      fb_sh  <= {fb_sh[1:0], fb_in};
    end
  end

  assign ref_rise  = ref_sh[1] & ~ref_sh[2];
  assign fb_rise   = fb_sh[1] & ~fb_sh[2];
  assign both      = up_q & dn_q;
  assign cmp_end   = both && (ovc == OV_LAST);
  assign width_now = {1'b0, pw} + (CNT_W+1)'(1);
  assign narrow    = width_now <= (CNT_W+1)'(LIMIT);
  assign good_nx   = (good == LK_FULL) ? good : good + LKW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0; dn_q <= 1'b0; pend_r <= 1'b0; pend_f <= 1'b0; ovc <= '0;
    end else if (inhibit) begin
      up_q <= 1'b0; dn_q <= 1'b0; pend_r <= 1'b0; pend_f <= 1'b0; ovc <= '0;
    end else if (both) begin
      if (cmp_end) begin
        up_q   <= pend_r | ref_rise;
        dn_q   <= pend_f | fb_rise;
        pend_r <= 1'b0;
        pend_f <= 1'b0;
        ovc    <= '0;
      end else begin
        ovc    <= ovc + OVW'(1);
        pend_r <= pend_r | ref_rise;
        pend_f <= pend_f | fb_rise;
      end
    end else begin
      up_q <= up_q | ref_rise;
      dn_q <= dn_q | fb_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw <= '0; good <= '0; lock_q <= 1'b0;
    end else if (inhibit) begin
      pw <= '0; good <= '0; lock_q <= 1'b0;
    end else if (cmp_end) begin
      pw <= '0;
      if (narrow) begin
        good   <= good_nx;
        lock_q <= (good_nx == LK_FULL);
      end else begin
        good   <= '0;
        lock_q <= 1'b0;
      end
    end else if (up_q | dn_q) begin
      if (pw != '1) pw <= pw + CNT_W'(1);
    end
  end

  assign up         = up_q & ~inhibit;
  assign dn         = dn_q & ~inhibit;
  assign pulse_out  = up | dn;
  assign drv_en     = pulse_out;
  assign drv_src    = up;
  assign drv_snk    = dn;
  assign xor_out    = ~inhibit & (ref_sh[1] ^ fb_sh[1]);
  assign shared_out = bias_mode ? pulse_out : xor_out;
  assign locked     = lock_q & ~inhibit;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int OVERLAP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic inhibit,
  input logic up,
  input logic dn,
  input logic drv_en,
  input logic pulse_out,
  input logic xor_out,
  input logic locked
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (up && dn) run <= (run == 16'hFFFF) ? run : run + 16'd1;
    else run <= '0;
  end

  assert_overlap_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up && dn) && !(up && dn) && !inhibit && !$past(inhibit))
      |-> (run != 0 && (run % OVERLAP) == 0));

  assert_dn_clears_in_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dn) && !inhibit) |-> $past(up));

  assert_up_clears_in_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(up) && !inhibit) |-> $past(dn));

  assert_inhibit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!up && !dn && !drv_en && !pulse_out && !xor_out && !locked));

  assert_inhibit_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit) |-> (!up && !dn && !locked));

  assert_lock_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pulse_out));
endmodule

bind pfd_lock pfd_lock_chk #(.OVERLAP(OVERLAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .up(up), .dn(dn),
  .drv_en(drv_en), .pulse_out(pulse_out), .xor_out(xor_out), .locked(locked)
);

// File: tb/sim_pfd_lock.sv
`timescale 1ns/1ps
module sim_pfd_lock;
  localparam int OV = 3;
  localparam int TL = 2;
  localparam int LK = 4;

  logic clk = 1'b0, rst_n = 1'b0, inhibit = 1'b0, bias_mode = 1'b0, ref_in = 1'b0, fb_in = 1'b0;
  logic inh_nx = 1'b0, bias_nx = 1'b0;
  logic up, dn, drv_en, drv_src, drv_snk, pulse_out, xor_out, shared_out, locked;
  int checks = 0, errors = 0;
  bit done = 0;

  pfd_lock #(.OVERLAP(OV), .TOL(TL), .LOCK_COUNT(LK), .CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .bias_mode(bias_mode),
    .ref_in(ref_in), .fb_in(fb_in), .up(up), .dn(dn), .drv_en(drv_en),
    .drv_src(drv_src), .drv_snk(drv_snk), .pulse_out(pulse_out),
    .xor_out(xor_out), .shared_out(shared_out), .locked(locked));

  always #2.5 clk = ~clk;

  int rh[3], fh[3];
  int mu, md, pr, pf, ovc, pw, good, lk;

  always @(posedge clk) begin
    int rr, fr, w;
    if (!rst_n) begin
      rh = '{0, 0, 0}; fh = '{0, 0, 0};
      mu = 0; md = 0; pr = 0; pf = 0; ovc = 0; pw = 0; good = 0; lk = 0;
    end else begin
      rr = (rh[1] == 1 && rh[2] == 0);
      fr = (fh[1] == 1 && fh[2] == 0);
      rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = int'(ref_in);
      fh[2] = fh[1]; fh[1] = fh[0]; fh[0] = int'(fb_in);
      if (inhibit) begin
        mu = 0; md = 0; pr = 0; pf = 0; ovc = 0; pw = 0; good = 0; lk = 0;
      end else if (mu != 0 && md != 0) begin
        if (ovc == OV - 1) begin
          w = pw + 1;
          if (w <= OV + TL) begin
            if (good < LK) good++;
            lk = (good >= LK);
          end else begin
            good = 0; lk = 0;
          end
          mu = pr | rr; md = pf | fr; pr = 0; pf = 0; ovc = 0; pw = 0;
        end else begin
          ovc++; pr |= rr; pf |= fr; pw++;
        end
      end else begin
        if (mu != 0 || md != 0) pw++;
        mu |= rr; md |= fr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int eu, ed, ex, ep;
    eu = (mu != 0 && !inhibit); ed = (md != 0 && !inhibit);
    ep = eu | ed;
    ex = inhibit ? 0 : (rh[1] ^ fh[1]);
    check(up == eu && dn == ed, "R2 model up/dn", {up, dn}, eu * 2 + ed);
    check(drv_en == ep && drv_src == eu && drv_snk == ed, "R4 model drive",
          {drv_en, drv_src, drv_snk}, ep * 4 + eu * 2 + ed);
    check(pulse_out == ep, "R5 model pulse", pulse_out, ep);
    check(xor_out == ex, "R6 model xor", xor_out, ex);
    check(shared_out == (bias_mode ? ep : ex), "R7 model shared", shared_out, bias_mode ? ep : ex);
    check(locked == (lk != 0 && !inhibit), "R10 model lock", locked, lk != 0 && !inhibit);
  endtask

  task automatic step(input logic r, input logic f);
    @(posedge clk);
    #1;
    ref_in = r; fb_in = f; inhibit = inh_nx; bias_mode = bias_nx;
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic pair(input int dr, input int hr, input int df, input int hf,
                      output int uc, output int dc);
    uc = 0; dc = 0;
    for (int i = 0; i < 40; i++) begin
      step(i >= dr && i < dr + hr, i >= df && i < df + hf);
      uc += int'(up); dc += int'(dn);
    end
  endtask

  task automatic retrig(input int k, output int uc, output int dc);
    uc = 0; dc = 0;
    for (int i = 0; i < 40; i++) begin
      step(i == 0 || (i >= k && i < k + 6), i == 0 || (i >= 8 && i < 14));
      uc += int'(up); dc += int'(dn);
    end
  endtask

  task automatic clear_pulse();
    inh_nx = 1'b1; step(0, 0); step(0, 0);
    inh_nx = 1'b0; step(0, 0); step(0, 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual 0 expected 1");
    report();
  end

  initial begin
    int uc, dc;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!up && !dn && !drv_en, "R4 reset drive idle", {up, dn, drv_en}, 0);
    check(!pulse_out && !locked, "R5 reset pulse idle", {pulse_out, locked}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) step(0, 0);

    pair(0, 12, 4, 12, uc, dc);
    check(uc == 4 + OV, "R2 lead up width", uc, 4 + OV);
    check(dc == OV, "R2 lead dn width", dc, OV);
    pair(5, 12, 0, 12, uc, dc);
    check(dc == 5 + OV, "R2 lag dn width", dc, 5 + OV);
    check(uc == OV, "R2 lag up width", uc, OV);
    pair(0, 12, 0, 12, uc, dc);
    check(uc == OV && dc == OV, "R3 zero error overlap", uc * 10 + dc, OV * 11);
    pair(0, 2, 2, 20, uc, dc);
    check(uc == 2 + OV && dc == OV, "R1 duty cycle ignored", uc * 10 + dc, (2 + OV) * 10 + OV);

    retrig(2, uc, dc);
    check(uc == 11 && dc == 6, "R9 edge inside overlap held", uc * 10 + dc, 116);
    retrig(3, uc, dc);
    check(uc == 11 && dc == 6, "R9 edge on clearing clock held", uc * 10 + dc, 116);
    retrig(4, uc, dc);
    check(uc == 10 && dc == 6, "R9 edge after clear", uc * 10 + dc, 106);

    pair(0, 12, 4, 12, uc, dc);
    pair(0, 12, 0, 12, uc, dc);
    pair(0, 12, 2, 12, uc, dc);
    pair(0, 12, 0, 12, uc, dc);
    check(!locked, "R10 not locked after three narrow", locked, 0);
    pair(0, 12, 1, 12, uc, dc);
    check(locked, "R10 locked after four narrow", locked, 1);
    pair(3, 12, 0, 12, uc, dc);
    check(!locked, "R10 lock dropped on wide comparison", locked, 0);

    uc = 0; dc = 0;
    for (int i = 0; i < 180; i++) begin
      step((i % 6) < 3, (i % 10) < 5);
      uc += int'(up); dc += int'(dn);
    end
    check(uc > dc, "R11 faster reference drives up", uc, dc);
    clear_pulse();
    uc = 0; dc = 0;
    for (int i = 0; i < 180; i++) begin
      step((i % 10) < 5, (i % 6) < 3);
      uc += int'(up); dc += int'(dn);
    end
    check(dc > uc, "R11 faster feedback drives down", dc, uc);
    clear_pulse();

    repeat (8) step(1, 1);
    repeat (4) step(0, 1);
    check(!up && !dn, "R1 falling edge ignored", {up, dn}, 0);
    check(xor_out, "R6 xor high on mismatch", xor_out, 1);
    check(shared_out, "R7 shared carries xor", shared_out, 1);
    bias_nx = 1'b1; step(0, 1);
    check(!shared_out, "R7 shared carries pulse", shared_out, 0);
    bias_nx = 1'b0;
    repeat (4) step(0, 0);
    check(!xor_out, "R6 xor low on match", xor_out, 0);

    inh_nx = 1'b1;
    repeat (6) step(1, 0);
    check(!up && !drv_en, "R8 inhibit blocks edge", {up, drv_en}, 0);
    inh_nx = 1'b0;
    repeat (4) step(1, 0);
    check(!up, "R8 edge during inhibit dropped", up, 0);
    repeat (2) step(0, 0);
    repeat (6) step(1, 0);
    check(up && drv_src && !drv_snk, "R4 source only while up", {drv_en, drv_src, drv_snk}, 6);
    inh_nx = 1'b1; step(1, 0);
    check(!up && !pulse_out && !drv_en, "R8 inhibit forces outputs low", {up, pulse_out, drv_en}, 0);
    inh_nx = 1'b0;
    repeat (3) step(1, 0);
    check(!up, "R8 state cleared by inhibit", up, 0);
    repeat (4) step(0, 0);
    report();
  end
endmodule